// File: doc/BRIEF.md
# Wide Packet Bus Formatter

This block takes a packet stream that arrives one byte per accepted cycle and assembles it into 512-bit receive-bus beats. Each byte comes with a channel tag, an end-of-packet marker and an error flag. Bytes fill the beat from the most significant lane downwards. A beat is released when all 64 lanes are filled or when the last byte of the packet arrives.

Each released beat carries a one-cycle valid qualifier, start and end markers, the packet's channel, an empty-lane count and an error indication. The output side cannot stall, so every beat must be taken the cycle it is presented. On the input side, a ready signal paces the byte source. It drops for one cycle after the last byte of each packet, which gives a single-cycle gap between packets.

Top module: `wide_pkt_packer`

## Requirements
- R1: While reset is high, `inReady` and `outEna` are 0. In the first cycle after reset is released, `inReady` is 1 and `outEna` is 0.
- R2: The first byte of a beat appears on `outData[511:504]` and the second on `[503:496]`. Each later byte takes the next 8 bits downward.
- R3: Every beat of a packet except its last carries exactly 64 bytes, with `outEop` = 0 and `outMty` = 0.
- R4: On an end beat with no error, `outMty` equals 64 minus the number of valid bytes. Unused low byte lanes are driven to zero.
- R5: The first beat of every packet has `outSop` = 1, and no other beat does. A packet of 64 bytes or fewer gives one beat with `outSop` and `outEop` both 1.
- R6: `outChan` carries the `inChan` value sampled with the packet's first byte, on every beat of that packet. Later changes of `inChan` within the packet have no effect.
- R7: An `inErr` seen on any accepted byte of a packet is reported as `outErr` = 1 on that packet's end beat. `outErr` is 0 on every other beat.
- R8: When `outErr` = 1, `outMty[2:0]` is 000 and `outMty[5:3]` holds the bits of the normal empty count.
- R9: `inReady` is 0 in the cycle after a byte with `inLast` = 1 is accepted, and 1 in every other cycle out of reset.
- R10: A beat is presented (`outEna` = 1 for one cycle) in the cycle after the byte that completes it is accepted. `outEna` is 0 in all other cycles.
- R11: A 257-byte packet gives 5 beats, and the last beat has an empty count of 63. If the packet is errored, the last beat has an empty count of 56 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Byte source offers a byte |
| inReady | output | 1 | Byte accepted when high together with inValid |
| inByte | input | 8 | Packet byte |
| inLast | input | 1 | Byte is the last of its packet |
| inErr | input | 1 | Error flag on this byte |
| inChan | input | 8 | Channel tag, sampled on first byte of a packet |
| outEna | output | 1 | Beat valid qualifier |
| outSop | output | 1 | Beat starts a packet |
| outEop | output | 1 | Beat ends a packet |
| outErr | output | 1 | Packet errored (end beat only) |
| outChan | output | 8 | Packet channel |
| outMty | output | 6 | Empty low byte lanes on the end beat |
| outData | output | 512 | Beat data, first byte in the top lane |

## Verification
Two events can land on the same beat: the end of a packet that has an error, and a partly filled last beat. When both happen, the error masking and the empty count computed from the lanes interact. The bench provokes this with errored packets of 3, 8 and 257 bytes, whose normal empty counts are 61, 56 and 63. The expected masked counts are 56, 56 and 56, and each is compared beat by beat against a behavioural byte-queue model. A second collision is a beat that is both start and end, where a full 64-byte packet fills the last lane at the same moment as its end marker. The bench checks that this gives a single beat and no empty beat after it.

// File: rtl/wide_pkt_packer_pkg.sv
package wide_pkt_packer_pkg;

  typedef struct packed {
    logic write;  // accepted byte lands in a lane
    logic emit;   // beat completes this cycle
    logic sop;    // beat being completed is a packet's first
    logic eop;    // beat being completed is a packet's last
    logic err;    // errored end beat
  } packStrb_t;

endpackage

// File: rtl/wide_pkt_packer_ctrl.sv
module wide_pkt_packer_ctrl
  import wide_pkt_packer_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int CHAN_W     = 8,
  parameter int ERR_ZERO_W = 3,
  localparam int LANE_W    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inLast,
  input  logic              inErr,
  input  logic [CHAN_W-1:0] inChan,
  output logic              inReady,
  output packStrb_t         strb,
  output logic [LANE_W-1:0] laneIdx,
  output logic [LANE_W-1:0] mtyNext,
  output logic [CHAN_W-1:0] chanNext
);

  logic              inPkt;
  logic              errSticky;
  logic              gap;
  logic              sopNext;
  logic [CHAN_W-1:0] chanHold;
  logic              accept;
  logic              lastLane;
  logic [LANE_W-1:0] mtyRaw;

  assign inReady  = !rst && !gap;
  assign accept   = inValid && inReady;
  assign lastLane = (laneIdx == LANE_W'(LANES - 1));
  assign chanNext = inPkt ? chanHold : inChan;

  always_comb begin
    strb.write = accept;
    strb.emit  = accept && (inLast || lastLane);
    strb.eop   = accept && inLast;
    strb.sop   = sopNext;
    strb.err   = accept && inLast && (errSticky || inErr);
    mtyRaw     = strb.eop ? (LANE_W'(LANES - 1) - laneIdx) : '0;
    mtyNext    = mtyRaw;
    if (strb.err) mtyNext[ERR_ZERO_W-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      laneIdx   <= '0;
      inPkt     <= 1'b0;
      errSticky <= 1'b0;
      gap       <= 1'b0;
      sopNext   <= 1'b1;
      chanHold  <= '0;
    end else begin
      gap <= accept && inLast;
      if (strb.emit) sopNext <= inLast;
      if (accept) begin
        if (inLast) begin
          laneIdx   <= '0;
          inPkt     <= 1'b0;
          errSticky <= 1'b0;
        end else begin
          laneIdx   <= lastLane ? '0 : laneIdx + 1'b1;
          inPkt     <= 1'b1;
          errSticky <= errSticky || inErr;
          chanHold  <= chanNext;
        end
      end
    end
  end

  // R9: one-cycle gap after the last byte of a packet
  assert_ready_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && inLast) |=> !inReady);

  // R9: no gap after a byte that does not end a packet
  assert_ready_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && !inLast) |=> inReady);

endmodule

// File: rtl/wide_pkt_packer_dp.sv
module wide_pkt_packer_dp
  import wide_pkt_packer_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int BYTE_W   = 8,
  parameter int CHAN_W   = 8,
  localparam int LANE_W  = $clog2(LANES),
  localparam int DATA_W  = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  packStrb_t         strb,
  input  logic [LANE_W-1:0] laneIdx,
  input  logic [LANE_W-1:0] mtyNext,
  input  logic [CHAN_W-1:0] chanNext,
  input  logic [BYTE_W-1:0] inByte,
  output logic              outEna,
  output logic              outSop,
  output logic              outEop,
  output logic              outErr,
  output logic [CHAN_W-1:0] outChan,
  output logic [LANE_W-1:0] outMty,
  output logic [DATA_W-1:0] outData
);

  logic [BYTE_W-1:0] accLane [LANES];
  logic [DATA_W-1:0] mergedWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] nextLane;
    assign nextLane = (strb.write && laneIdx == LANE_W'(g)) ? inByte : accLane[g];
    assign mergedWord[DATA_W-1-g*BYTE_W -: BYTE_W] = nextLane;
    always_ff @(posedge clk) begin
      if (rst || strb.emit) accLane[g] <= '0;
      else                  accLane[g] <= nextLane;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outEna  <= 1'b0;
      outSop  <= 1'b0;
      outEop  <= 1'b0;
      outErr  <= 1'b0;
      outChan <= '0;
      outMty  <= '0;
      outData <= '0;
    end else begin
      outEna <= strb.emit;
      outSop <= strb.emit && strb.sop;
      outEop <= strb.emit && strb.eop;
      outErr <= strb.emit && strb.err;
      if (strb.emit) begin
        outChan <= chanNext;
        outMty  <= mtyNext;
        outData <= mergedWord;
      end
    end
  end

  // checker state: previous beat's channel and end marker
  logic [CHAN_W-1:0] prevChan;
  logic              prevEop;
  always_ff @(posedge clk) begin
    if (rst) begin
      prevChan <= '0;
      prevEop  <= 1'b1;
    end else if (outEna) begin
      prevChan <= outChan;
      prevEop  <= outEop;
    end
  end

  assert_err_on_end_R7: assert property (@(posedge clk) disable iff (rst)
    outErr |-> (outEna && outEop));

  assert_err_mty_R8: assert property (@(posedge clk) disable iff (rst)
    (outEna && outErr) |-> (outMty[2:0] == 3'b000));

  assert_full_beat_R3: assert property (@(posedge clk) disable iff (rst)
    (outEna && !outEop) |-> (outMty == '0));

  assert_sop_follows_eop_R5: assert property (@(posedge clk) disable iff (rst)
    outEna |-> (outSop == prevEop));

  assert_chan_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (outEna && !outSop) |-> (outChan == prevChan));

  assert_low_lanes_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (outEna && outEop) |->
      ((outData & ~({DATA_W{1'b1}} << (outMty * BYTE_W))) == '0));

endmodule

// File: rtl/wide_pkt_packer.sv
module wide_pkt_packer
  import wide_pkt_packer_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int BYTE_W     = 8,
  parameter int CHAN_W     = 8,
  parameter int ERR_ZERO_W = 3,
  localparam int LANE_W    = $clog2(LANES),
  localparam int DATA_W    = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inLast,
  input  logic              inErr,
  input  logic [CHAN_W-1:0] inChan,
  output logic              outEna,
  output logic              outSop,
  output logic              outEop,
  output logic              outErr,
  output logic [CHAN_W-1:0] outChan,
  output logic [LANE_W-1:0] outMty,
  output logic [DATA_W-1:0] outData
);

  packStrb_t         strb;
  logic [LANE_W-1:0] laneIdx;
  logic [LANE_W-1:0] mtyNext;
  logic [CHAN_W-1:0] chanNext;

  wide_pkt_packer_ctrl #(
    .LANES(LANES), .CHAN_W(CHAN_W), .ERR_ZERO_W(ERR_ZERO_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast), .inErr(inErr),
    .inChan(inChan), .inReady(inReady), .strb(strb), .laneIdx(laneIdx),
    .mtyNext(mtyNext), .chanNext(chanNext)
  );

  wide_pkt_packer_dp #(
    .LANES(LANES), .BYTE_W(BYTE_W), .CHAN_W(CHAN_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .laneIdx(laneIdx), .mtyNext(mtyNext),
    .chanNext(chanNext), .inByte(inByte), .outEna(outEna), .outSop(outSop),
    .outEop(outEop), .outErr(outErr), .outChan(outChan), .outMty(outMty),
    .outData(outData)
  );

endmodule

// File: tb/wide_pkt_packer_bench.sv
module wide_pkt_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 64;
  localparam int DATA_W = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inLast = 1'b0, inErr = 1'b0;
  logic [7:0] inByte = '0, inChan = '0;
  logic inReady, outEna, outSop, outEop, outErr;
  logic [7:0] outChan;
  logic [5:0] outMty;
  logic [DATA_W-1:0] outData;

  int checks = 0, errors = 0;

  // model state
  logic [7:0] bq[$];
  bit   mErr = 0, mFirstBeat = 1, mInPkt = 0, mGap = 0;
  logic [7:0] mChan = 0;
  bit   eEna, eSop, eEop, eErr;
  logic [7:0] eChan;
  logic [5:0] eMty;
  logic [DATA_W-1:0] eData;
  int   beatsThisPkt = 0, lastPktBeats = 0;
  logic [5:0] lastMty;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_pkt_packer u_wide_pkt_packer (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inByte(inByte),
    .inLast(inLast), .inErr(inErr), .inChan(inChan), .outEna(outEna),
    .outSop(outSop), .outEop(outEop), .outErr(outErr), .outChan(outChan),
    .outMty(outMty), .outData(outData)
  );

  task automatic chk(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: at negedge with inputs set, update model, advance, compare
  task automatic step(output bit accepted);
    bit acc;
    chk(inReady == !mGap, "R9 inReady", inReady, !mGap);
    acc = inValid && inReady;
    accepted = acc;
    eEna = 0; eSop = 0; eEop = 0; eErr = 0;
    if (acc) begin
      if (!mInPkt) mChan = inChan;
      mInPkt = !inLast;
      bq.push_back(inByte);
      mErr = mErr | inErr;
      if (inLast || bq.size() == LANES) begin
        eEna = 1; eSop = mFirstBeat; eEop = inLast; eChan = mChan;
        eErr = inLast && mErr;
        eMty = inLast ? 6'(LANES - bq.size()) : 6'd0;
        if (eErr) eMty[2:0] = 3'b000;
        eData = '0;
        for (int k = 0; k < bq.size(); k++) eData[DATA_W-1-8*k -: 8] = bq[k];
        bq.delete();
        mFirstBeat = inLast;
        if (inLast) mErr = 0;
      end
    end
    mGap = acc && inLast;
    @(posedge clk);
    @(negedge clk);
    chk(outEna == eEna, "R10 outEna timing", outEna, eEna);
    if (eEna && outEna) begin
      chk(outSop == eSop, "R5 outSop", outSop, eSop);
      chk(outEop == eEop, "R3 outEop", outEop, eEop);
      chk(outChan == eChan, "R6 outChan", outChan, eChan);
      chk(outData == eData, "R2 R4 outData", outData, eData);
      chk(outMty == eMty, eErr ? "R8 outMty" : "R4 outMty", outMty, eMty);
      chk(outErr == eErr, "R7 outErr", outErr, eErr);
      beatsThisPkt++;
      if (outEop) begin
        lastPktBeats = beatsThisPkt;
        lastMty = outMty;
        beatsThisPkt = 0;
      end
    end
  endtask

  task automatic idle(int n);
    bit a;
    inValid = 0;
    for (int i = 0; i < n; i++) step(a);
  endtask

  task automatic sendPkt(int len, logic [7:0] ch, int errAt, int gapPct);
    bit a;
    for (int i = 0; i < len; i++) begin
      while (gapPct > 0 && ($urandom % 100) < gapPct) begin
        inValid = 0; inChan = 8'($urandom);
        step(a);
      end
      do begin
        inValid = 1;
        inByte  = 8'($urandom);
        inLast  = (i == len - 1);
        inErr   = (i == errAt);
        inChan  = (i == 0) ? ch : 8'($urandom);  // R6: mid-packet changes ignored
        step(a);
      end while (!a);
    end
    inValid = 0; inLast = 0; inErr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(inReady == 0, "R1 ready in reset", inReady, 0);
    chk(outEna == 0, "R1 outEna in reset", outEna, 0);
    rst = 0;
    @(negedge clk);
    chk(inReady == 1, "R1 ready after reset", inReady, 1);
    chk(outEna == 0, "R1 outEna after reset", outEna, 0);

    sendPkt(1, 8'h11, -1, 0);   idle(2);   // R5 single byte
    sendPkt(64, 8'h22, -1, 0);  idle(2);   // R5 exact bus width
    chk(lastPktBeats == 1, "R5 64-byte beats", lastPktBeats, 1);
    sendPkt(65, 8'h33, -1, 0);  idle(2);   // R3 full then one byte
    sendPkt(257, 8'h44, -1, 0); idle(2);   // R11 clean
    chk(lastPktBeats == 5, "R11 beats clean", lastPktBeats, 5);
    chk(lastMty == 63, "R11 mty clean", lastMty, 63);
    sendPkt(257, 8'h55, 100, 0); idle(2);  // R11 errored
    chk(lastPktBeats == 5, "R11 beats errored", lastPktBeats, 5);
    chk(lastMty == 56, "R11 mty errored", lastMty, 56);
    sendPkt(3, 8'h66, 0, 0);    idle(1);   // R8 mty 61 -> 56
    sendPkt(8, 8'h77, 7, 0);    idle(1);   // R8 mty 56 stays 56
    // back-to-back packets, no idle
    sendPkt(10, 8'h01, -1, 0);
    sendPkt(128, 8'h02, 64, 0);
    sendPkt(5, 8'h03, -1, 0);
    idle(2);
    for (int p = 0; p < 30; p++) begin
      int len = 1 + ($urandom % 200);
      int ea  = (($urandom % 3) == 0) ? int'($urandom % len) : -1;
      sendPkt(len, 8'($urandom), ea, 30);
    end
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule